// File: doc/BRIEF.md
# Gauge Power-Mode and Conversion Scheduler

This block decides when a battery gauge is awake and when each averaged voltage conversion period ends. It runs on a fast system clock with a one-cycle enable from a 32 kHz time base, and it counts everything in ticks of that base. A conversion-done strobe marks the end of each averaging window. The first window after reset or after a restart is short (125 ms). Every later window is long (500 ms).

The block reaches low-power sleep in two ways. In the first, the two serial bus lines are both held low for a 2.0 s timeout, and a later rising edge on either line wakes it. In the second, a sleep control bit from the register file forces sleep, and bus activity does not end that state: only clearing the bit does. While asleep the window count is frozen, and the next result after wake arrives one long window later. A restart (quick-start) request comes either from a synchronized rising edge on a dedicated pin or from a one-cycle command strobe. It re-runs the sequence as after reset, short first window included.

Top module: `gauge_sched`

## Requirements
- R1: While reset is asserted and on its release, `sleep_o`, `conv_done_o` and `restart_o` are all 0.
- R2: The first `conv_done_o` pulse after reset release comes after FIRST = TICK_HZ*125/1000 ticks. With a tick every cycle it is seen FIRST+2 clock edges after the release, two of which are taken by reset synchronization.
- R3: After the first window, `conv_done_o` pulses once every PERIOD = TICK_HZ*500/1000 ticks. Each pulse lasts one cycle.
- R4: Every window and timeout counter advances only in cycles where `tick_i` is 1. With a tick every N cycles, the window becomes N times longer in clock cycles.
- R5: When `scl_i` and `sda_i` are both held low for BUS_LOW = TICK_HZ*2000/1000 ticks, `sleep_o` rises. With a tick every cycle this is BUS_LOW+2 edges after the lines fall, because of the two-flop input synchronizers.
- R6: A high level on either bus line, even for one cycle, restarts the bus-low count from zero.
- R7: From bus-entered sleep, a rising edge on `scl_i` or on `sda_i` clears `sleep_o` on the third clock edge after the edge is driven.
- R8: `sleep_bit_i` = 1 sets `sleep_o` on the next clock edge. Bus edges do not clear that sleep. Returning the bit to 0 clears `sleep_o` on the next edge.
- R9: No `conv_done_o` pulse occurs while `sleep_o` is 1. The first pulse after wake comes exactly PERIOD ticks after the wake edge.
- R10: A rising edge on `qstrt_i` (synchronized by two flops) gives exactly one `restart_o` pulse on the third edge after it. Holding the pin high gives no further pulses. The next `conv_done_o` follows FIRST ticks after the restart.
- R11: A one-cycle `qs_cmd_i` gives `restart_o` on the next edge, followed by a short FIRST-tick window and then PERIOD-tick windows. `restart_o` and `conv_done_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle enable from the 32 kHz time base |
| scl_i | input | 1 | Serial bus clock line level |
| sda_i | input | 1 | Serial bus data line level |
| qstrt_i | input | 1 | Quick-start pin, asynchronous |
| sleep_bit_i | input | 1 | Sleep control bit from the register file |
| qs_cmd_i | input | 1 | One-cycle quick-start command strobe |
| sleep_o | output | 1 | 1 while the gauge is in sleep |
| conv_done_o | output | 1 | One-cycle pulse at the end of each conversion window |
| restart_o | output | 1 | One-cycle pulse when the gauging sequence restarts |

## Verification
A window counter that slips or reloads the wrong limit shows up at the very next `conv_done_o` as an interval off by whole ticks. The bench measures these intervals exactly after reset, restart and wake, under several tick spacings. A wrong sleep state shows at `sleep_o` within three clock edges of the stimulus that should change it. Sleep that does not freeze the window shows up as a strobe during a long idle stretch. A sleep-source mix-up (a bus edge waking register-forced sleep) turns `sleep_o` low in the middle of the bus toggling.

// File: rtl/gauge_sched_pkg.sv
package gauge_sched_pkg;

  // Raw asynchronous pins grouped for the synchronizer
  typedef struct packed {
    logic qstrt;
    logic sda;
    logic scl;
  } pins_t;

  // Milliseconds to time-base ticks, exact integer arithmetic
  function automatic int unsigned ms_to_ticks(input int unsigned hz, input int unsigned ms);
    longint unsigned prod;
    prod = longint'(hz) * longint'(ms);
    return int'(prod / 1000);
  endfunction

endpackage

// File: rtl/gauge_sched_sync.sv
module gauge_sched_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = sh_q[STAGES-1];
  end

endmodule

// File: rtl/gauge_sched_sleep.sv
module gauge_sched_sleep #(
  parameter int unsigned BUS_LOW_TICKS = 65536,
  localparam int unsigned LW = $clog2(BUS_LOW_TICKS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic scl_s,
  input  logic sda_s,
  input  logic sleep_bit_i,
  output logic sleep_o,
  output logic sleep_d_o,
  output logic wake_o
);

  localparam logic [LW-1:0] LOW_LAST = LW'(BUS_LOW_TICKS - 1);

  logic [LW-1:0] lcnt_q, lcnt_d;
  logic          bus_slp_q, bus_slp_d;
  logic          reg_slp_q;
  logic          scl_prev_q, sda_prev_q;
  logic          rise, both_low;

  assign rise     = (scl_s & ~scl_prev_q) | (sda_s & ~sda_prev_q);
  assign both_low = ~scl_s & ~sda_s;

  always_comb begin
    lcnt_d    = lcnt_q;
    bus_slp_d = bus_slp_q;
    if (bus_slp_q) begin
      lcnt_d = '0;
      if (rise) bus_slp_d = 1'b0;
    end else if (!both_low || reg_slp_q) begin
      lcnt_d = '0;
    end else if (tick_i) begin
      if (lcnt_q == LOW_LAST) begin
        lcnt_d    = '0;
        bus_slp_d = 1'b1;
      end else begin
        lcnt_d = lcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcnt_q     <= '0;
      bus_slp_q  <= 1'b0;
      reg_slp_q  <= 1'b0;
      scl_prev_q <= 1'b0;
      sda_prev_q <= 1'b0;
    end else begin
      lcnt_q     <= lcnt_d;
      bus_slp_q  <= bus_slp_d;
      reg_slp_q  <= sleep_bit_i;
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  assign sleep_o   = bus_slp_q | reg_slp_q;
  assign sleep_d_o = bus_slp_d | sleep_bit_i;
  assign wake_o    = sleep_o & ~sleep_d_o;

endmodule

// File: rtl/gauge_sched_timer.sv
module gauge_sched_timer #(
  parameter int unsigned FIRST_TICKS  = 4096,
  parameter int unsigned PERIOD_TICKS = 16384,
  localparam int unsigned MAXT = (FIRST_TICKS > PERIOD_TICKS) ? FIRST_TICKS : PERIOD_TICKS,
  localparam int unsigned CW   = $clog2(MAXT)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic run_i,
  input  logic wake_i,
  input  logic qs_i,
  output logic done_o,
  output logic restart_o
);

  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic          first_q, first_d;
  logic          done_q, done_d;
  logic          rst_q, rst_d;

  assign lim = first_q ? CW'(FIRST_TICKS - 1) : CW'(PERIOD_TICKS - 1);

  always_comb begin
    cnt_d   = cnt_q;
    first_d = first_q;
    done_d  = 1'b0;
    rst_d   = 1'b0;
    if (qs_i) begin
      cnt_d   = '0;
      first_d = 1'b1;
      rst_d   = 1'b1;
    end else if (wake_i) begin
      cnt_d   = '0;
      first_d = 1'b0;
    end else if (run_i && tick_i) begin
      if (cnt_q == lim) begin
        cnt_d   = '0;
        first_d = 1'b0;
        done_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
      done_q  <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      first_q <= first_d;
      done_q  <= done_d;
      rst_q   <= rst_d;
    end
  end

  assign done_o    = done_q;
  assign restart_o = rst_q;

endmodule

// File: rtl/gauge_sched.sv
module gauge_sched
  import gauge_sched_pkg::*;
#(
  parameter int unsigned TICK_HZ     = 32768,
  parameter int unsigned FIRST_MS    = 125,
  parameter int unsigned PERIOD_MS   = 500,
  parameter int unsigned BUS_LOW_MS  = 2000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic scl_i,
  input  logic sda_i,
  input  logic qstrt_i,
  input  logic sleep_bit_i,
  input  logic qs_cmd_i,
  output logic sleep_o,
  output logic conv_done_o,
  output logic restart_o
);

  localparam int unsigned FIRST_T  = ms_to_ticks(TICK_HZ, FIRST_MS);
  localparam int unsigned PERIOD_T = ms_to_ticks(TICK_HZ, PERIOD_MS);
  localparam int unsigned BUSLOW_T = ms_to_ticks(TICK_HZ, BUS_LOW_MS);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sh_q;
  logic       rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_n_int = rst_sh_q[1];

  pins_t raw, syn;
  assign raw.scl   = scl_i;
  assign raw.sda   = sda_i;
  assign raw.qstrt = qstrt_i;

  gauge_sched_sync #(.W($bits(pins_t)), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d_i   (raw),
    .q_o   (syn)
  );

  // Quick-start: pin rising edge or command strobe
  logic qstrt_prev_q, qs;
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) qstrt_prev_q <= 1'b0;
    else            qstrt_prev_q <= syn.qstrt;
  end
  assign qs = (syn.qstrt & ~qstrt_prev_q) | qs_cmd_i;

  logic sleep_d, wake;

  gauge_sched_sleep #(.BUS_LOW_TICKS(BUSLOW_T)) u_sleep (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .tick_i      (tick_i),
    .scl_s       (syn.scl),
    .sda_s       (syn.sda),
    .sleep_bit_i (sleep_bit_i),
    .sleep_o     (sleep_o),
    .sleep_d_o   (sleep_d),
    .wake_o      (wake)
  );

  gauge_sched_timer #(.FIRST_TICKS(FIRST_T), .PERIOD_TICKS(PERIOD_T)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .tick_i    (tick_i),
    .run_i     (~sleep_d),
    .wake_i    (wake),
    .qs_i      (qs),
    .done_o    (conv_done_o),
    .restart_o (restart_o)
  );

endmodule

// File: rtl/gauge_sched_chk.sv
module gauge_sched_chk (
  input logic clk,
  input logic rst_n,
  input logic sleep_bit_i,
  input logic sleep_o,
  input logic conv_done_o,
  input logic restart_o
);

  logic live_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  // R9
  no_conv_in_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_o |-> !conv_done_o);

  // R11
  restart_conv_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({restart_o, conv_done_o}));

  // R8
  reg_sleep_force_chk: assert property (@(posedge clk) disable iff (!live_q)
    sleep_bit_i |=> sleep_o);

  // R8
  reg_sleep_hold_chk: assert property (@(posedge clk) disable iff (!live_q)
    $fell(sleep_o) |-> !$past(sleep_bit_i));

endmodule

bind gauge_sched gauge_sched_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n_int),
  .sleep_bit_i (sleep_bit_i),
  .sleep_o     (sleep_o),
  .conv_done_o (conv_done_o),
  .restart_o   (restart_o)
);

// File: tb/gauge_sched_bench.sv
`timescale 1ns/1ps
module gauge_sched_bench;

  localparam int unsigned HZ     = 64;
  localparam int          FIRST  = HZ * 125 / 1000;
  localparam int          PERIOD = HZ * 500 / 1000;
  localparam int          BUSLOW = HZ * 2000 / 1000;
  localparam int          LIMIT  = 20000;

  logic clk = 1'b0;
  logic rst_n, tick_i, scl_i, sda_i, qstrt_i, sleep_bit_i, qs_cmd_i;
  logic sleep_o, conv_done_o, restart_o;

  int checks = 0;
  int errors = 0;
  int div = 1;
  int tph = 0;
  int conv_cnt = 0;
  int rst_cnt = 0;

  always #2.5 clk = ~clk;

  gauge_sched #(.TICK_HZ(HZ)) u_gauge_sched (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .scl_i(scl_i), .sda_i(sda_i),
    .qstrt_i(qstrt_i), .sleep_bit_i(sleep_bit_i), .qs_cmd_i(qs_cmd_i),
    .sleep_o(sleep_o), .conv_done_o(conv_done_o), .restart_o(restart_o)
  );

  always @(negedge clk) begin
    tph    <= (tph + 1 >= div) ? 0 : tph + 1;
    tick_i <= (tph == 0);
    if (conv_done_o === 1'b1) conv_cnt <= conv_cnt + 1;
    if (restart_o === 1'b1)   rst_cnt  <= rst_cnt + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic until_conv(output int n);
    n = 0;
    do begin @(posedge clk); n++; @(negedge clk); end
    while (!conv_done_o && n < LIMIT);
  endtask

  task automatic until_sleep(input logic lvl, output int n);
    n = 0;
    do begin @(posedge clk); n++; @(negedge clk); end
    while (sleep_o !== lvl && n < LIMIT);
  endtask

  task automatic until_restart(output int n);
    n = 0;
    do begin @(posedge clk); n++; @(negedge clk); end
    while (!restart_o && n < LIMIT);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual expired expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, base;
    rst_n = 1'b0; tick_i = 1'b1; scl_i = 1'b1; sda_i = 1'b1;
    qstrt_i = 1'b0; sleep_bit_i = 1'b0; qs_cmd_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 sleep in reset", sleep_o, 0);
    chk("R1 conv in reset", conv_done_o, 0);
    chk("R1 restart in reset", restart_o, 0);
    rst_n = 1'b1;
    until_conv(n);
    chk("R2 first window after reset", n, FIRST + 2);
    chk("R1 sleep after release", sleep_o, 0);
    for (int k = 0; k < 2; k++) begin
      until_conv(n);
      chk("R3 long window", n, PERIOD);
    end

    // R4: sweep of tick spacings
    for (int d = 2; d <= 4; d++) begin
      div = d;
      until_conv(n);
      until_conv(n);
      chk("R4 window scales with tick spacing", n, PERIOD * d);
    end
    div = 1;
    until_conv(n);

    // R5 bus-low sleep entry, R9 freeze
    scl_i = 1'b0; sda_i = 1'b0;
    until_sleep(1'b1, n);
    chk("R5 bus-low timeout", n, BUSLOW + 2);
    base = conv_cnt;
    repeat (3 * PERIOD) @(negedge clk);
    chk("R9 no strobe while asleep", conv_cnt - base, 0);

    // R7 wake on scl
    scl_i = 1'b1;
    until_sleep(1'b0, n);
    chk("R7 wake on scl edge", n, 3);
    until_conv(n);
    chk("R9 first result after wake", n, PERIOD);

    // R6 glitch restarts the count
    scl_i = 1'b0;
    repeat (BUSLOW - 4) @(negedge clk);
    chk("R6 awake before glitch", sleep_o, 0);
    scl_i = 1'b1;
    @(negedge clk);
    scl_i = 1'b0;
    until_sleep(1'b1, n);
    chk("R6 count restarted by high level", n, BUSLOW + 2);

    // R7 wake on sda
    sda_i = 1'b1;
    until_sleep(1'b0, n);
    chk("R7 wake on sda edge", n, 3);
    scl_i = 1'b1;

    // R8 register sleep ignores bus edges
    sleep_bit_i = 1'b1;
    @(negedge clk);
    chk("R8 sleep bit forces sleep", sleep_o, 1);
    base = conv_cnt;
    for (int k = 0; k < 3; k++) begin
      scl_i = 1'b0; sda_i = 1'b0;
      repeat (5) @(negedge clk);
      scl_i = 1'b1; sda_i = 1'b1;
      repeat (5) @(negedge clk);
    end
    repeat (2 * PERIOD) @(negedge clk);
    chk("R8 bus edges do not wake", sleep_o, 1);
    chk("R9 no strobe in register sleep", conv_cnt - base, 0);
    sleep_bit_i = 1'b0;
    @(negedge clk);
    chk("R8 clearing bit wakes", sleep_o, 0);
    until_conv(n);
    chk("R9 window after register wake", n, PERIOD);

    // R10 quick-start pin
    base = rst_cnt;
    qstrt_i = 1'b1;
    until_restart(n);
    chk("R10 pin edge to restart", n, 3);
    until_conv(n);
    chk("R10 short window after pin restart", n, FIRST);
    repeat (3 * FIRST) @(negedge clk);
    chk("R10 single restart while held", rst_cnt - base, 1);
    qstrt_i = 1'b0;
    until_conv(n);

    // R11 command strobe mid-window
    repeat (PERIOD / 2) @(negedge clk);
    qs_cmd_i = 1'b1;
    @(negedge clk);
    qs_cmd_i = 1'b0;
    chk("R11 command restart latency", restart_o, 1);
    until_conv(n);
    chk("R11 short window after command", n, FIRST);
    until_conv(n);
    chk("R11 long window follows", n, PERIOD);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule